// File: doc/BRIEF.md
# Show-ahead synchronous FIFO buffer

A single-clock first-in, first-out buffer that stores a parameterised number of words of parameterised width. A producer stores a word by holding the write enable high across a rising clock edge. A consumer sees the oldest stored word on the data output straight away, with no clock edge in between, in the way an asynchronous RAM returns a read. If the read enable is high at a rising edge, that word is removed and the next-oldest word appears on the output.

An occupancy counter drives the full and empty flags. A write offered while the buffer is full is refused, and so is a read offered while it is empty. Both pointers wrap around the storage array. The asynchronous, active-high reset empties the buffer and also clears every storage word.

Top module: `showahead_fifo`

## Requirements
- R1: While reset is high and after it is released, empty is 1 and full is 0. Reset clears every storage word to zero, so with the buffer empty after reset the data output reads 0.
- R2: At a rising edge where the write enable is high and the buffer is not full, the input word is stored behind every word already held.
- R3: While the read enable is high and the buffer is not empty, the data output carries the oldest stored word in the same cycle, before any clock edge.
- R4: At a rising edge where the read enable is high and the buffer is not empty, the oldest word is removed and the next-oldest word is presented at once.
- R5: Empty goes low after the first accepted write and goes high again when the last stored word has been read out.
- R6: Full is 1 exactly when DEPTH words are held. Full and empty are never both 1.
- R7: A write while full leaves the stored words, the write pointer and the occupancy unchanged. The refused word never appears at the output.
- R8: A read while empty leaves the read pointer and the occupancy unchanged. A word written afterwards is the next word presented.
- R9: With a read and a write at the same edge, both take effect when the buffer is neither empty nor full, and the occupancy stays the same. When the buffer is empty only the write takes effect. When it is full only the read takes effect.
- R10: Both pointers wrap from index DEPTH-1 back to 0, and word order is kept across the wrap.
- R11: Writes and reads work on consecutive cycles and also with idle cycles between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| wr_en | input | 1 | Store `din` at the next rising edge |
| rd_en | input | 1 | Remove the head word at the next rising edge |
| din | input | WIDTH | Word to store |
| dout | output | WIDTH | Oldest stored word, presented combinationally |
| full | output | 1 | All DEPTH slots occupied |
| empty | output | 1 | No word held |

## Verification
The bench builds the buffer with DEPTH set to 16 and WIDTH set to 8, so a full buffer can be reached in sixteen writes. With that depth, a streaming run of forty words takes both pointers past the last index more than once. The refused write when full, the combined read and write when full, and the order of words after a wrap can all be checked against a simple count of words in and out. The default depth of 64 is elaborated as well, but the bench does not run it.

// File: rtl/showahead_fifo_pkg.sv
package showahead_fifo_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b10,
        OP_POP  = 2'b01,
        OP_BOTH = 2'b11
    } fifo_op_e;
endpackage

// File: rtl/showahead_fifo_store.sv
module showahead_fifo_store #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata = mem_q[raddr];

    // R2: an accepted write lands in the addressed slot
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/showahead_fifo_ctrl.sv
module showahead_fifo_ctrl
    import showahead_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic             wr_ok,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             full,
    output logic             empty
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        rd_ok;
    fifo_op_e    op;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        wr_ok = wr_en && (st_q.cnt != FULL_CNT);
        rd_ok = rd_en && (st_q.cnt != '0);
        op    = fifo_op_e'({wr_ok, rd_ok});
        st_d  = st_q;
        case (op)
            OP_PUSH: begin
                st_d.wr_ptr = bump(st_q.wr_ptr);
                st_d.cnt    = st_q.cnt + 1'b1;
            end
            OP_POP: begin
                st_d.rd_ptr = bump(st_q.rd_ptr);
                st_d.cnt    = st_q.cnt - 1'b1;
            end
            OP_BOTH: begin
                st_d.wr_ptr = bump(st_q.wr_ptr);
                st_d.rd_ptr = bump(st_q.rd_ptr);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr = st_q.wr_ptr;
    assign rd_ptr = st_q.rd_ptr;
    assign full   = (st_q.cnt == FULL_CNT);
    assign empty  = (st_q.cnt == '0);

    // R6: occupancy never exceeds the depth
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= FULL_CNT);

    // R7: a lone write into a full buffer changes nothing
    assert_full_write_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == FULL_CNT && wr_en && !rd_en) |=>
            (st_q.cnt == FULL_CNT && $stable(st_q.wr_ptr)));

    // R8: a lone read from an empty buffer changes nothing
    assert_empty_read_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == '0 && rd_en && !wr_en) |=>
            (st_q.cnt == '0 && $stable(st_q.rd_ptr)));

    // R9: read plus write in the middle range keeps occupancy
    assert_both_keep_count_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt != '0 && st_q.cnt != FULL_CNT && wr_en && rd_en) |=>
            $stable(st_q.cnt));

    // R10: read pointer wraps to zero after the last index
    assert_rd_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (st_q.rd_ptr == LAST_IDX && rd_en && st_q.cnt != '0) |=>
            (st_q.rd_ptr == '0));

    // R10: write pointer wraps to zero after the last index
    assert_wr_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (st_q.wr_ptr == LAST_IDX && wr_en && st_q.cnt != FULL_CNT) |=>
            (st_q.wr_ptr == '0));
endmodule

// File: rtl/showahead_fifo.sv
module showahead_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             wr_ok;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    showahead_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wr_ok  (wr_ok),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .full   (full),
        .empty  (empty)
    );

    showahead_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_ok),
        .waddr (wr_ptr),
        .wdata (din),
        .raddr (rd_ptr),
        .rdata (dout)
    );

    // R6: the two flags exclude each other
    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    // R5: an accepted write into an empty buffer clears empty
    assert_empty_falls_R5: assert property (@(posedge clk) disable iff (rst)
        (empty && wr_en) |=> !empty);
endmodule

// File: tb/showahead_fifo_bench.sv
module showahead_fifo_bench;
    localparam int DEPTH = 16;
    localparam int WIDTH = 8;
    localparam int NVEC  = 21;

    logic             clk = 1'b0;
    logic             rst;
    logic             wr_en;
    logic             rd_en;
    logic [WIDTH-1:0] din;
    logic [WIDTH-1:0] dout;
    logic             full;
    logic             empty;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    showahead_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_showahead_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .din(din), .dout(dout), .full(full), .empty(empty)
    );

    // {wr, rd, chk_dout, exp_empty, exp_full, din[7:0], exp_dout[7:0]}
    // flags are those seen before the edge that applies this row
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h20, 8'h00},
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hAF, 8'h00},
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h34, 8'h00},
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h14, 8'h00},
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hB1, 8'h00},
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00},
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h20},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'hAF},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h34},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h14},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'hB1},
        {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00},
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h5A, 8'h00},
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h5A},
        {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00},
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h11, 8'h00},
        {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h22, 8'h11},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h22},
        {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at the falling edge, settle, then the caller checks before the rising edge
    task automatic drive(input logic w, input logic r, input logic [WIDTH-1:0] d);
        @(negedge clk);
        wr_en = w;
        rd_en = r;
        din   = d;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        din   = '0;
        rst   = 1'b1;
        #1;
        check("R1 empty in reset", 32'(empty), 32'd1);
        check("R1 full in reset", 32'(full), 32'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        rst = 1'b1;
        wr_en = 1'b0;
        rd_en = 1'b0;
        din = '0;
        repeat (2) @(posedge clk);
        do_reset();

        // vector table: spread and back-to-back traffic (R2 R3 R4 R5 R11)
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][20], VEC[i][19], VEC[i][15:8]);
            check("R5 empty flag", 32'(empty), 32'(VEC[i][17]));
            check("R6 full flag", 32'(full), 32'(VEC[i][16]));
            if (VEC[i][18]) begin
                check("R3 R4 R11 head word", 32'(dout), 32'(VEC[i][7:0]));
            end
        end

        // fill to the top (R6), refused write (R7), read+write when full (R9)
        for (int i = 0; i < DEPTH; i++) begin
            drive(1'b1, 1'b0, 8'(i + 1));
            check("R6 not full while filling", 32'(full), 32'd0);
        end
        drive(1'b1, 1'b0, 8'hEE);
        check("R6 full at depth", 32'(full), 32'd1);
        drive(1'b0, 1'b0, 8'h00);
        check("R7 still full after refused write", 32'(full), 32'd1);
        drive(1'b1, 1'b1, 8'h77);
        check("R9 head when full", 32'(dout), 32'd1);
        drive(1'b0, 1'b0, 8'h00);
        check("R9 only read taken when full", 32'(full), 32'd0);
        for (int i = 1; i < DEPTH; i++) begin
            drive(1'b0, 1'b1, 8'h00);
            check("R7 R10 order after full", 32'(dout), 32'(i + 1));
        end
        drive(1'b0, 1'b0, 8'h00);
        check("R7 R9 refused words absent", 32'(empty), 32'd1);

        // read while empty (R8), then read+write while empty (R9)
        drive(1'b0, 1'b1, 8'h00);
        drive(1'b0, 1'b1, 8'h00);
        check("R8 empty held", 32'(empty), 32'd1);
        drive(1'b1, 1'b1, 8'h4D);
        drive(1'b0, 1'b1, 8'h00);
        check("R9 write taken when empty", 32'(dout), 32'h4D);
        drive(1'b0, 1'b0, 8'h00);
        check("R8 R9 empty after pop", 32'(empty), 32'd1);
        drive(1'b1, 1'b0, 8'h3C);
        drive(1'b0, 1'b1, 8'h00);
        check("R8 next word after empty read", 32'(dout), 32'h3C);

        // streaming across several wraps (R10 R11)
        drive(1'b1, 1'b0, 8'd0);
        drive(1'b1, 1'b0, 8'd1);
        drive(1'b1, 1'b0, 8'd2);
        for (int k = 3; k < 40; k++) begin
            drive(1'b1, 1'b1, 8'(k));
            check("R10 streamed order", 32'(dout), 32'(k - 3));
        end
        for (int k = 37; k < 40; k++) begin
            drive(1'b0, 1'b1, 8'h00);
            check("R10 drain order", 32'(dout), 32'(k));
        end
        drive(1'b0, 1'b0, 8'h00);
        check("R5 empty after stream", 32'(empty), 32'd1);

        // reset clears storage (R1)
        for (int i = 0; i < 4; i++) begin
            drive(1'b1, 1'b0, 8'hC0 + 8'(i));
        end
        do_reset();
        drive(1'b0, 1'b1, 8'h00);
        check("R1 storage cleared", 32'(dout), 32'd0);
        check("R1 empty after reset", 32'(empty), 32'd1);
        check("R1 full after reset", 32'(full), 32'd0);
        drive(1'b0, 1'b0, 8'h00);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule